// File: doc/BRIEF.md
# Secure Connection Control Sequencer

This block is the top-level connection controller of a client transport engine. It watches a user-driven connection-on level, takes a new connection only on a rising edge while it is not busy, and captures the per-connection settings at that moment. The settings are the destination address and ports, the source port, and the protocol-negotiation length and string. It also holds a set of network-wide settings: the local hardware address, the local IP and the gateway IP. These are captured whenever the network-set request is seen while the block is not busy.

After a connection is accepted, the sequencer walks through its phases: address resolution, then handshake, then data transfer, then closing. It advances on done and fail strobes from external sub-engines, which are not part of this block. A close is requested by dropping connection-on. The close is clean only if the handshake, transmit and receive activities all report idle.

Every fault ends in a single error phase. On entry to that phase the block raises a one-cycle alert interrupt together with a 16-bit alert code. The error phase holds until the user releases connection-on.

Top module: `conn_seq_top`

## Requirements
- R1: A connection request is accepted only when connection-on rises while conn_busy_o is 0. conn_busy_o is 1 in the cycle after acceptance and stays 1 until the block returns to idle.
- R2: A rise of connection-on while conn_busy_o is 1 is ignored. If connection-on is still high when the block returns to idle, no connection starts until a new rise is seen.
- R3: The network settings (hardware address, local IP, gateway IP) are captured only on a cycle where net_set_i is 1 and conn_busy_o is 0. Otherwise they hold their value.
- R4: The destination IP, destination port, source port and ALPN length and string are captured only in the cycle a request is accepted. alpn_omit_o is 1 when the captured length is 0.
- R5: A request whose ALPN length is greater than 16 goes directly to the error phase and raises alert code 0x1003.
- R6: Dropping connection-on in the handshake or data phase while hs_busy_i, tx_busy_i or rx_busy_i is 1 raises alert code 0x1001. With all three at 0, the block instead spends one cycle in the closing phase and then returns to idle, with no alert.
- R7: alert_int_o is a one-cycle pulse, visible the cycle after the fault is sampled. alert_code_o[15] is 1 for a remote-reported fault and 0 for a local one, and alert_code_o[14:0] carries the code.
- R8: After an alert, the block stays in the error phase (busy) while connection-on is 1. It returns to idle the cycle after connection-on is seen low.
- R9: idle_to_i in the handshake or data phase raises code 0x1000. resolve_fail_i in the resolve phase raises code 0x1002.
- R10: phase_o encodes idle=0, resolve=1, handshake=2, data=3, closing=4, error=5. resolve_done_i moves resolve to handshake, and hs_done_i moves handshake to data.
- R11: When several faults occur in the same cycle, only one alert pulse is produced. A local fault wins over a remote one. Among local faults the order is abnormal close first, then idle timeout, then other local errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| net_set_i | input | 1 | Request to capture the network settings |
| src_mac_i | input | 48 | Local hardware address |
| src_ip_i | input | 32 | Local IP address |
| gw_ip_i | input | 32 | Gateway IP address |
| conn_on_i | input | 1 | Connection-on level |
| dst_ip_i | input | 32 | Destination IP address |
| dst_port_i | input | 16 | Destination port |
| src_port_i | input | 16 | Source port |
| alpn_len_i | input | 5 | ALPN string length in bytes |
| alpn_str_i | input | 128 | ALPN string |
| resolve_done_i | input | 1 | Address resolution finished |
| resolve_fail_i | input | 1 | Address resolution found no route |
| hs_done_i | input | 1 | Handshake finished |
| hs_busy_i | input | 1 | Handshake activity in progress |
| tx_busy_i | input | 1 | Transmit activity in progress |
| rx_busy_i | input | 1 | Receive activity in progress |
| idle_to_i | input | 1 | Peer idle timeout |
| loc_err_i | input | 1 | Locally detected fault |
| loc_err_code_i | input | 15 | Code of the local fault |
| rem_err_i | input | 1 | Fault reported by the peer |
| rem_err_code_i | input | 15 | Code of the peer fault |
| conn_busy_o | output | 1 | Connection operation in progress |
| phase_o | output | 3 | Current phase |
| alpn_omit_o | output | 1 | Captured ALPN length is zero |
| cfg_src_mac_o | output | 48 | Captured hardware address |
| cfg_src_ip_o | output | 32 | Captured local IP |
| cfg_gw_ip_o | output | 32 | Captured gateway IP |
| cur_dst_ip_o | output | 32 | Captured destination IP |
| cur_dst_port_o | output | 16 | Captured destination port |
| cur_src_port_o | output | 16 | Captured source port |
| cur_alpn_len_o | output | 5 | Captured ALPN length |
| cur_alpn_str_o | output | 128 | Captured ALPN string |
| alert_int_o | output | 1 | One-cycle alert pulse |
| alert_code_o | output | 16 | Alert code: direction bit and value |

## Verification
The assertions take it as given that the sub-engine strobes behave as follows: resolve_done_i and resolve_fail_i arrive only during resolution, and hs_done_i arrives only during the handshake. The assertions also assume every strobe lasts a single cycle, and that the busy inputs describe the live connection. The stimulus respects these assumptions. It raises each strobe for exactly one cycle, and only after the phase output has shown the matching phase. It changes every input only on the falling edge. Simultaneous faults are produced on purpose, to exercise the priority rule.

// File: rtl/conn_seq_pkg.sv
package conn_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RESOLVE = 3'd1,
    PH_HSHAKE  = 3'd2,
    PH_XFER    = 3'd3,
    PH_CLOSING = 3'd4,
    PH_ERROR   = 3'd5
  } phase_e;

  localparam int unsigned CODE_W = 15;

  localparam logic [CODE_W-1:0] CODE_IDLE_TO   = 15'h1000;
  localparam logic [CODE_W-1:0] CODE_ABN_CLOSE = 15'h1001;
  localparam logic [CODE_W-1:0] CODE_UNREACH   = 15'h1002;
  localparam logic [CODE_W-1:0] CODE_ALPN_BAD  = 15'h1003;

endpackage

// File: rtl/conn_alert_arb.sv
module conn_alert_arb #(
  parameter int N_LOC = 3,
  parameter int CW    = 15
) (
  input  logic [N_LOC-1:0]    loc_vld_i,
  input  logic [N_LOC*CW-1:0] loc_code_i,
  input  logic                rem_vld_i,
  input  logic [CW-1:0]       rem_code_i,
  output logic                evt_vld_o,
  output logic [CW:0]         evt_code_o
);

  // Fixed priority: lowest local index first, remote only when no local fault.
  always_comb begin
    evt_vld_o  = (|loc_vld_i) | rem_vld_i;
    evt_code_o = {1'b1, rem_code_i};
    for (int i = N_LOC - 1; i >= 0; i--) begin
      if (loc_vld_i[i]) evt_code_o = {1'b0, loc_code_i[i*CW +: CW]};
    end
  end

  always_comb begin
    if (|loc_vld_i) begin
      assert_local_wins_R11: assert (evt_code_o[CW] == 1'b0);
    end
  end

endmodule

// File: rtl/conn_param_latch.sv
module conn_param_latch #(
  parameter int MAC_W  = 48,
  parameter int IP_W   = 32,
  parameter int PORT_W = 16,
  parameter int LEN_W  = 5,
  parameter int STR_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              net_set_i,
  input  logic [MAC_W-1:0]  src_mac_i,
  input  logic [IP_W-1:0]   src_ip_i,
  input  logic [IP_W-1:0]   gw_ip_i,
  input  logic              accept_i,
  input  logic [IP_W-1:0]   dst_ip_i,
  input  logic [PORT_W-1:0] dst_port_i,
  input  logic [PORT_W-1:0] src_port_i,
  input  logic [LEN_W-1:0]  alpn_len_i,
  input  logic [STR_W-1:0]  alpn_str_i,
  output logic [MAC_W-1:0]  src_mac_o,
  output logic [IP_W-1:0]   src_ip_o,
  output logic [IP_W-1:0]   gw_ip_o,
  output logic [IP_W-1:0]   dst_ip_o,
  output logic [PORT_W-1:0] dst_port_o,
  output logic [PORT_W-1:0] src_port_o,
  output logic [LEN_W-1:0]  alpn_len_o,
  output logic [STR_W-1:0]  alpn_str_o,
  output logic              alpn_omit_o
);

  logic net_en;
  assign net_en = net_set_i & ~busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_mac_o <= '0;
      src_ip_o  <= '0;
      gw_ip_o   <= '0;
    end else if (net_en) begin
      src_mac_o <= src_mac_i;
      src_ip_o  <= src_ip_i;
      gw_ip_o   <= gw_ip_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_ip_o   <= '0;
      dst_port_o <= '0;
      src_port_o <= '0;
      alpn_len_o <= '0;
      alpn_str_o <= '0;
    end else if (accept_i) begin
      dst_ip_o   <= dst_ip_i;
      dst_port_o <= dst_port_i;
      src_port_o <= src_port_i;
      alpn_len_o <= alpn_len_i;
      alpn_str_o <= alpn_str_i;
    end
  end

  assign alpn_omit_o = (alpn_len_o == '0);

  assert_net_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(src_mac_o) && $stable(src_ip_o) && $stable(gw_ip_o)));

  assert_param_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> ($stable(dst_ip_o) && $stable(dst_port_o) && $stable(alpn_len_o)));

endmodule

// File: rtl/conn_fsm.sv
module conn_fsm
  import conn_seq_pkg::*;
#(
  parameter int LEN_W    = 5,
  parameter int ALPN_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conn_on_i,
  input  logic [LEN_W-1:0]  alpn_len_i,
  input  logic              resolve_done_i,
  input  logic              resolve_fail_i,
  input  logic              hs_done_i,
  input  logic              hs_busy_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              idle_to_i,
  input  logic              loc_err_i,
  input  logic [CODE_W-1:0] loc_err_code_i,
  input  logic              rem_err_i,
  input  logic [CODE_W-1:0] rem_err_code_i,
  output logic              accept_o,
  output logic              busy_o,
  output phase_e            phase_o,
  output logic              alert_o,
  output logic [CODE_W:0]   alert_code_o
);

  localparam int N_LOC = 3;

  phase_e            state_q, state_d;
  logic              conn_q;
  logic              alert_d;
  logic [CODE_W:0]   code_d;
  logic              in_conn;
  logic              any_busy;
  logic [N_LOC-1:0]  loc_vld;
  logic [N_LOC*CODE_W-1:0] loc_code;
  logic              rem_vld;
  logic              evt_vld;
  logic [CODE_W:0]   evt_code;

  assign in_conn  = (state_q == PH_HSHAKE) || (state_q == PH_XFER);
  assign any_busy = hs_busy_i | tx_busy_i | rx_busy_i;
  assign accept_o = (state_q == PH_IDLE) & conn_on_i & ~conn_q;

  // Index 0 has the highest priority.
  assign loc_vld[0] = in_conn & ~conn_on_i & any_busy;
  assign loc_vld[1] = in_conn & idle_to_i;
  assign loc_vld[2] = in_conn & loc_err_i;
  assign loc_code   = {loc_err_code_i, CODE_IDLE_TO, CODE_ABN_CLOSE};
  assign rem_vld    = in_conn & rem_err_i;

  conn_alert_arb #(
    .N_LOC (N_LOC),
    .CW    (CODE_W)
  ) u_arb (
    .loc_vld_i  (loc_vld),
    .loc_code_i (loc_code),
    .rem_vld_i  (rem_vld),
    .rem_code_i (rem_err_code_i),
    .evt_vld_o  (evt_vld),
    .evt_code_o (evt_code)
  );

  always_comb begin
    state_d = state_q;
    alert_d = 1'b0;
    code_d  = alert_code_o;
    unique case (state_q)
      PH_IDLE: begin
        if (accept_o) begin
          if (alpn_len_i > LEN_W'(ALPN_MAX)) begin
            state_d = PH_ERROR;
            alert_d = 1'b1;
            code_d  = {1'b0, CODE_ALPN_BAD};
          end else begin
            state_d = PH_RESOLVE;
          end
        end
      end
      PH_RESOLVE: begin
        if (resolve_fail_i) begin
          state_d = PH_ERROR;
          alert_d = 1'b1;
          code_d  = {1'b0, CODE_UNREACH};
        end else if (resolve_done_i) begin
          state_d = PH_HSHAKE;
        end
      end
      PH_HSHAKE, PH_XFER: begin
        if (evt_vld) begin
          state_d = PH_ERROR;
          alert_d = 1'b1;
          code_d  = evt_code;
        end else if (!conn_on_i) begin
          state_d = PH_CLOSING;
        end else if ((state_q == PH_HSHAKE) && hs_done_i) begin
          state_d = PH_XFER;
        end
      end
      PH_CLOSING: state_d = PH_IDLE;
      PH_ERROR: begin
        if (!conn_on_i) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= PH_IDLE;
      conn_q       <= 1'b0;
      alert_o      <= 1'b0;
      alert_code_o <= '0;
    end else begin
      state_q <= state_d;
      conn_q  <= conn_on_i;
      alert_o <= alert_d;
      if (alert_d) alert_code_o <= code_d;
    end
  end

  assign busy_o  = (state_q != PH_IDLE);
  assign phase_o = state_q;

  assert_open_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && conn_on_i && !$past(conn_on_i)) |=> busy_o);

  assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && phase_o != PH_CLOSING && phase_o != PH_ERROR) |=> busy_o);

  assert_alpn_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && conn_on_i && !$past(conn_on_i) && alpn_len_i > LEN_W'(ALPN_MAX))
      |=> (alert_o && alert_code_o == {1'b0, CODE_ALPN_BAD}));

  assert_abn_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == PH_HSHAKE || phase_o == PH_XFER) && !conn_on_i && any_busy)
      |=> (alert_o && alert_code_o == {1'b0, CODE_ABN_CLOSE}));

  assert_alert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |=> !alert_o);

  assert_err_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_ERROR && conn_on_i) |=> (phase_o == PH_ERROR));

  assert_unreach_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_RESOLVE && resolve_fail_i)
      |=> (alert_o && alert_code_o == {1'b0, CODE_UNREACH}));

endmodule

// File: rtl/conn_seq_top.sv
module conn_seq_top
  import conn_seq_pkg::*;
#(
  parameter int MAC_W    = 48,
  parameter int IP_W     = 32,
  parameter int PORT_W   = 16,
  parameter int LEN_W    = 5,
  parameter int STR_W    = 128,
  parameter int ALPN_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_set_i,
  input  logic [MAC_W-1:0]  src_mac_i,
  input  logic [IP_W-1:0]   src_ip_i,
  input  logic [IP_W-1:0]   gw_ip_i,
  input  logic              conn_on_i,
  input  logic [IP_W-1:0]   dst_ip_i,
  input  logic [PORT_W-1:0] dst_port_i,
  input  logic [PORT_W-1:0] src_port_i,
  input  logic [LEN_W-1:0]  alpn_len_i,
  input  logic [STR_W-1:0]  alpn_str_i,
  input  logic              resolve_done_i,
  input  logic              resolve_fail_i,
  input  logic              hs_done_i,
  input  logic              hs_busy_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              idle_to_i,
  input  logic              loc_err_i,
  input  logic [14:0]       loc_err_code_i,
  input  logic              rem_err_i,
  input  logic [14:0]       rem_err_code_i,
  output logic              conn_busy_o,
  output logic [2:0]        phase_o,
  output logic              alpn_omit_o,
  output logic [MAC_W-1:0]  cfg_src_mac_o,
  output logic [IP_W-1:0]   cfg_src_ip_o,
  output logic [IP_W-1:0]   cfg_gw_ip_o,
  output logic [IP_W-1:0]   cur_dst_ip_o,
  output logic [PORT_W-1:0] cur_dst_port_o,
  output logic [PORT_W-1:0] cur_src_port_o,
  output logic [LEN_W-1:0]  cur_alpn_len_o,
  output logic [STR_W-1:0]  cur_alpn_str_o,
  output logic              alert_int_o,
  output logic [15:0]       alert_code_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       accept;
  phase_e     phase;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  conn_fsm #(
    .LEN_W    (LEN_W),
    .ALPN_MAX (ALPN_MAX)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .conn_on_i      (conn_on_i),
    .alpn_len_i     (alpn_len_i),
    .resolve_done_i (resolve_done_i),
    .resolve_fail_i (resolve_fail_i),
    .hs_done_i      (hs_done_i),
    .hs_busy_i      (hs_busy_i),
    .tx_busy_i      (tx_busy_i),
    .rx_busy_i      (rx_busy_i),
    .idle_to_i      (idle_to_i),
    .loc_err_i      (loc_err_i),
    .loc_err_code_i (loc_err_code_i),
    .rem_err_i      (rem_err_i),
    .rem_err_code_i (rem_err_code_i),
    .accept_o       (accept),
    .busy_o         (conn_busy_o),
    .phase_o        (phase),
    .alert_o        (alert_int_o),
    .alert_code_o   (alert_code_o)
  );

  assign phase_o = phase;

  conn_param_latch #(
    .MAC_W  (MAC_W),
    .IP_W   (IP_W),
    .PORT_W (PORT_W),
    .LEN_W  (LEN_W),
    .STR_W  (STR_W)
  ) u_latch (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .busy_i      (conn_busy_o),
    .net_set_i   (net_set_i),
    .src_mac_i   (src_mac_i),
    .src_ip_i    (src_ip_i),
    .gw_ip_i     (gw_ip_i),
    .accept_i    (accept),
    .dst_ip_i    (dst_ip_i),
    .dst_port_i  (dst_port_i),
    .src_port_i  (src_port_i),
    .alpn_len_i  (alpn_len_i),
    .alpn_str_i  (alpn_str_i),
    .src_mac_o   (cfg_src_mac_o),
    .src_ip_o    (cfg_src_ip_o),
    .gw_ip_o     (cfg_gw_ip_o),
    .dst_ip_o    (cur_dst_ip_o),
    .dst_port_o  (cur_dst_port_o),
    .src_port_o  (cur_src_port_o),
    .alpn_len_o  (cur_alpn_len_o),
    .alpn_str_o  (cur_alpn_str_o),
    .alpn_omit_o (alpn_omit_o)
  );

endmodule

// File: tb/tb_conn_seq_top.sv
`timescale 1ns/1ps
module tb_conn_seq_top;

  localparam int P_IDLE = 0, P_RES = 1, P_HS = 2, P_XFER = 3, P_CLOSE = 4, P_ERR = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic net_set_i, conn_on_i;
  logic [47:0] src_mac_i;
  logic [31:0] src_ip_i, gw_ip_i, dst_ip_i;
  logic [15:0] dst_port_i, src_port_i;
  logic [4:0] alpn_len_i;
  logic [127:0] alpn_str_i;
  logic resolve_done_i, resolve_fail_i, hs_done_i, hs_busy_i, tx_busy_i, rx_busy_i;
  logic idle_to_i, loc_err_i, rem_err_i;
  logic [14:0] loc_err_code_i, rem_err_code_i;
  logic conn_busy_o, alpn_omit_o, alert_int_o;
  logic [2:0] phase_o;
  logic [47:0] cfg_src_mac_o;
  logic [31:0] cfg_src_ip_o, cfg_gw_ip_o, cur_dst_ip_o;
  logic [15:0] cur_dst_port_o, cur_src_port_o, alert_code_o;
  logic [4:0] cur_alpn_len_o;
  logic [127:0] cur_alpn_str_o;

  always #2.5 clk = ~clk;

  conn_seq_top dut (
    .clk(clk), .rst_n(rst_n), .net_set_i(net_set_i), .src_mac_i(src_mac_i),
    .src_ip_i(src_ip_i), .gw_ip_i(gw_ip_i), .conn_on_i(conn_on_i),
    .dst_ip_i(dst_ip_i), .dst_port_i(dst_port_i), .src_port_i(src_port_i),
    .alpn_len_i(alpn_len_i), .alpn_str_i(alpn_str_i),
    .resolve_done_i(resolve_done_i), .resolve_fail_i(resolve_fail_i),
    .hs_done_i(hs_done_i), .hs_busy_i(hs_busy_i), .tx_busy_i(tx_busy_i),
    .rx_busy_i(rx_busy_i), .idle_to_i(idle_to_i), .loc_err_i(loc_err_i),
    .loc_err_code_i(loc_err_code_i), .rem_err_i(rem_err_i),
    .rem_err_code_i(rem_err_code_i), .conn_busy_o(conn_busy_o),
    .phase_o(phase_o), .alpn_omit_o(alpn_omit_o),
    .cfg_src_mac_o(cfg_src_mac_o), .cfg_src_ip_o(cfg_src_ip_o),
    .cfg_gw_ip_o(cfg_gw_ip_o), .cur_dst_ip_o(cur_dst_ip_o),
    .cur_dst_port_o(cur_dst_port_o), .cur_src_port_o(cur_src_port_o),
    .cur_alpn_len_o(cur_alpn_len_o), .cur_alpn_str_o(cur_alpn_str_o),
    .alert_int_o(alert_int_o), .alert_code_o(alert_code_o)
  );

  typedef struct {
    int          cyc;
    string       req;
    int          phase;
    logic        busy;
    logic        alert;
    logic [15:0] code;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver side: push an expectation for 'dly' cycles ahead.
  task automatic expect_at(int dly, string req, int ph, logic busy, logic alert, logic [15:0] code);
    exp_t e;
    e.cyc = cyc + dly; e.req = req; e.phase = ph; e.busy = busy; e.alert = alert; e.code = code;
    q.push_back(e);
  endtask

  // Monitor: pops and compares on falling edges.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " phase"}, 128'(phase_o), 128'(e.phase));
      chk({e.req, " busy"}, 128'(conn_busy_o), 128'(e.busy));
      chk({e.req, " alert"}, 128'(alert_int_o), 128'(e.alert));
      if (e.alert) chk({e.req, " code"}, 128'(alert_code_o), 128'(e.code));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic open_to_data(string req);
    conn_on_i = 1'b1;
    expect_at(1, {req, "/R10 resolve"}, P_RES, 1'b1, 1'b0, 16'h0);
    step();
    resolve_done_i = 1'b1;
    expect_at(1, {req, "/R10 handshake"}, P_HS, 1'b1, 1'b0, 16'h0);
    step();
    resolve_done_i = 1'b0;
    hs_done_i = 1'b1;
    expect_at(1, {req, "/R10 data"}, P_XFER, 1'b1, 1'b0, 16'h0);
    step();
    hs_done_i = 1'b0;
  endtask

  // Fault strobe already applied by caller; checks pulse, wait and release.
  task automatic finish_error(string req, logic [15:0] code);
    expect_at(1, {req, " alert"}, P_ERR, 1'b1, 1'b1, code);
    expect_at(2, "R7 pulse ends", P_ERR, 1'b1, 1'b0, 16'h0);
    step();
    idle_to_i = 0; loc_err_i = 0; rem_err_i = 0; resolve_fail_i = 0;
    step();
    expect_at(1, "R8 wait in error", P_ERR, 1'b1, 1'b0, 16'h0);
    step();
    conn_on_i = 1'b0;
    hs_busy_i = 0; tx_busy_i = 0; rx_busy_i = 0;
    expect_at(1, "R8 release", P_IDLE, 1'b0, 1'b0, 16'h0);
    step();
    step();
  endtask

  initial begin
    rst_n = 0; net_set_i = 0; conn_on_i = 0;
    src_mac_i = '0; src_ip_i = '0; gw_ip_i = '0; dst_ip_i = '0;
    dst_port_i = '0; src_port_i = '0; alpn_len_i = '0; alpn_str_i = '0;
    resolve_done_i = 0; resolve_fail_i = 0; hs_done_i = 0;
    hs_busy_i = 0; tx_busy_i = 0; rx_busy_i = 0;
    idle_to_i = 0; loc_err_i = 0; rem_err_i = 0;
    loc_err_code_i = '0; rem_err_code_i = '0;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();

    // Reset state
    chk("R1 reset busy", 128'(conn_busy_o), 128'(0));
    chk("R10 reset phase", 128'(phase_o), 128'(P_IDLE));
    chk("R7 reset alert", 128'(alert_int_o), 128'(0));

    // R3: network settings captured when idle
    net_set_i = 1; src_mac_i = 48'h0A1B2C3D4E5F; src_ip_i = 32'hC0A80105; gw_ip_i = 32'hC0A80101;
    step();
    net_set_i = 0; src_ip_i = 32'h11111111;
    step();
    chk("R3 src ip captured", 128'(cfg_src_ip_o), 128'(32'hC0A80105));
    chk("R3 mac captured", 128'(cfg_src_mac_o), 128'(48'h0A1B2C3D4E5F));

    // R1/R4: clean open and close
    dst_ip_i = 32'hAC100009; dst_port_i = 16'd443; src_port_i = 16'd5000;
    alpn_len_i = 5'd3; alpn_str_i = 128'h683300;
    conn_on_i = 1;
    expect_at(1, "R1 accept", P_RES, 1'b1, 1'b0, 16'h0);
    step();
    dst_ip_i = 32'hDEADBEEF; alpn_len_i = 5'd0;
    net_set_i = 1; src_ip_i = 32'h22222222;
    step();
    net_set_i = 0;
    chk("R4 dst ip held", 128'(cur_dst_ip_o), 128'(32'hAC100009));
    chk("R4 dst port", 128'(cur_dst_port_o), 128'(16'd443));
    chk("R4 alpn len", 128'(cur_alpn_len_o), 128'(5'd3));
    chk("R4 alpn not omitted", 128'(alpn_omit_o), 128'(0));
    chk("R3 ignored while busy", 128'(cfg_src_ip_o), 128'(32'hC0A80105));
    resolve_done_i = 1;
    expect_at(1, "R10 to handshake", P_HS, 1'b1, 1'b0, 16'h0);
    step();
    resolve_done_i = 0; hs_done_i = 1;
    expect_at(1, "R10 to data", P_XFER, 1'b1, 1'b0, 16'h0);
    step();
    hs_done_i = 0;
    conn_on_i = 0;
    expect_at(1, "R6 clean close", P_CLOSE, 1'b1, 1'b0, 16'h0);
    step();
    // R2: rise during closing is ignored
    conn_on_i = 1;
    expect_at(1, "R6 back to idle", P_IDLE, 1'b0, 1'b0, 16'h0);
    expect_at(2, "R2 no restart", P_IDLE, 1'b0, 1'b0, 16'h0);
    expect_at(3, "R2 no restart", P_IDLE, 1'b0, 1'b0, 16'h0);
    repeat (3) step();
    conn_on_i = 0;
    step();

    // R5: ALPN length too long
    alpn_len_i = 5'd17;
    conn_on_i = 1;
    finish_error("R5 alpn 17", 16'h1003);

    // R4/R9: zero length omitted, unreachable
    alpn_len_i = 5'd0;
    conn_on_i = 1;
    step();
    chk("R4 alpn omitted", 128'(alpn_omit_o), 128'(1));
    resolve_fail_i = 1;
    finish_error("R9 unreachable", 16'h1002);

    // R6: abnormal close in handshake
    alpn_len_i = 5'd16;
    conn_on_i = 1;
    step();
    resolve_done_i = 1;
    step();
    resolve_done_i = 0;
    hs_busy_i = 1;
    conn_on_i = 0;
    expect_at(1, "R6 abnormal close hs", P_ERR, 1'b1, 1'b1, 16'h1001);
    expect_at(2, "R8 release low", P_IDLE, 1'b0, 1'b0, 16'h0);
    step();
    hs_busy_i = 0;
    step(); step();

    // R6: abnormal close in data with rx busy
    open_to_data("R6");
    rx_busy_i = 1;
    conn_on_i = 0;
    expect_at(1, "R6 abnormal close rx", P_ERR, 1'b1, 1'b1, 16'h1001);
    step();
    rx_busy_i = 0;
    step(); step();

    // R7: remote fault direction bit
    open_to_data("R7");
    rem_err_i = 1; rem_err_code_i = 15'h0123;
    finish_error("R7 remote", 16'h8123);

    // R7: local fault
    open_to_data("R7");
    loc_err_i = 1; loc_err_code_i = 15'h0042;
    finish_error("R7 local", 16'h0042);

    // R9: idle timeout
    open_to_data("R9");
    idle_to_i = 1;
    finish_error("R9 idle timeout", 16'h1000);

    // R11: local beats remote
    open_to_data("R11");
    loc_err_i = 1; loc_err_code_i = 15'h0055;
    rem_err_i = 1; rem_err_code_i = 15'h0077;
    finish_error("R11 local wins", 16'h0055);

    // R11: timeout beats other local and remote
    open_to_data("R11");
    idle_to_i = 1; loc_err_i = 1; loc_err_code_i = 15'h0066; rem_err_i = 1;
    finish_error("R11 timeout first", 16'h1000);

    // R11: abnormal close beats all
    open_to_data("R11");
    tx_busy_i = 1; idle_to_i = 1; rem_err_i = 1;
    conn_on_i = 0;
    expect_at(1, "R11 abnormal first", P_ERR, 1'b1, 1'b1, 16'h1001);
    expect_at(2, "R11 single pulse", P_IDLE, 1'b0, 1'b0, 16'h0);
    step();
    tx_busy_i = 0; idle_to_i = 0; rem_err_i = 0;
    repeat (3) step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule